// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Controller

This block sits between two memory-mapped hosts, called side A and side B. Each side owns eight 32-bit outbound mailbox words that it can write and read back. The other side can only read them, through a separate window. Every write that lands in a side's own mailbox rings a doorbell toward the other side. The doorbell is a sticky status bit that the receiving side clears by writing a one to it.

Each side has one status register holding the doorbells it has received and one enable register that masks them. The side's interrupt output is a registered level. It is high while any received doorbell is both set and enabled. A typical use is to pass a short message: one side fills a mailbox, the other side takes the interrupt, reads the message through its read-only window and clears the doorbell.

Both buses are single-cycle and byte addressed with a 14-bit address. Writes take effect at the clock edge. Read data is a combinational function of the address.

Top module: `mbox_doorbell_bridge`

## Requirements
- R1: A write to a side's own mailbox window (side A 0x0800-0x081F, side B 0x3A00-0x3A1F; slot n at base+4n) updates only the bytes whose byte-enable bit is set (be[k] covers data bits 8k+7:8k). Reading the same address returns the stored word.
- R2: Each side reads the other side's mailboxes at its peer window (side A 0x0900-0x091F, side B 0x3B00-0x3B1F). Writes to a peer window change no state on either side.
- R3: A mailbox write to slot n with at least one byte enable set raises bit 16+n of the other side's status register (side A status at 0x0040, side B status at 0x3060). A write with all byte enables clear raises nothing. Status bits 31:24 and 15:0 read as zero.
- R4: Status bits clear when written with one, provided byte enable 2 is set. Writing zero leaves a bit unchanged, and so does a write with byte enable 2 clear.
- R5: When a doorbell set and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The enable register (side A 0x0050, side B 0x3070) stores bits 23:16 when byte enable 2 is set. All of its other bits read as zero.
- R7: A side's interrupt output equals the OR of (status AND enable) as it stood after the previous clock edge. It therefore follows any change one cycle later.
- R8: A read from any address outside the four decoded regions of a side returns zero.
- R9: Reset clears every mailbox word, status bit and enable bit, and both interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| a_we | input | 1 | Side A write strobe |
| a_addr | input | 14 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_be | input | 4 | Side A byte enables |
| a_rdata | output | 32 | Side A read data for a_addr |
| a_irq | output | 1 | Side A interrupt level |
| b_we | input | 1 | Side B write strobe |
| b_addr | input | 14 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_be | input | 4 | Side B byte enables |
| b_rdata | output | 32 | Side B read data for b_addr |
| b_irq | output | 1 | Side B interrupt level |

## Verification
The hardest case to reach from the ports is a doorbell set racing a clear of the same bit. It needs one side writing its own mailbox slot n in exactly the cycle in which the other side writes a one into status bit 16+n. The bench drives both buses in the same cycle in every step. It runs a directed race on a bit that is already set, then keeps the race coming under random stimulus, where the address picks favour the status, enable and mailbox windows on both sides at once. Interrupt latency is checked in every step against the state that stood one cycle earlier.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DW  = 32;
  localparam int MBX_BW  = MBX_DW / 8;
  localparam int MBX_NUM = 8;
  localparam int MBX_AW  = 14;
  localparam int DB_LSB  = 16;

  typedef logic [MBX_DW-1:0]  word_t;
  typedef logic [MBX_NUM-1:0] mask_t;
  typedef logic [MBX_AW-1:0]  addr_t;

  // byte-lane merge of a write into a stored word
  function automatic word_t be_merge(word_t cur, word_t nxt, logic [MBX_BW-1:0] be);
    word_t r;
    r = cur;
    for (int k = 0; k < MBX_BW; k++)
      if (be[k]) r[8*k +: 8] = nxt[8*k +: 8];
    return r;
  endfunction

  // write-one-to-clear with set taking precedence
  function automatic mask_t rw1c_next(mask_t cur, mask_t setm, mask_t clrm);
    return (cur & ~clrm) | setm;
  endfunction

  // address falls in a window aligned to 2**lsb bytes
  function automatic logic win_hit(addr_t addr, addr_t base, int lsb);
    return (addr >> lsb) == (base >> lsb);
  endfunction
endpackage

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int NMB = MBX_NUM,
  localparam int IW = $clog2(NMB)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IW-1:0]              idx,
  input  word_t                      wdata,
  input  logic [MBX_BW-1:0]          be,
  output logic [NMB-1:0][MBX_DW-1:0] mbox,
  output logic [NMB-1:0]             ring
);
  for (genvar n = 0; n < NMB; n++) begin : g_slot
    logic hit;
    assign hit     = we && (idx == IW'(n));
    assign ring[n] = hit && (|be);
    always_ff @(posedge clk) begin
      if (!rst_n)   mbox[n] <= '0;
      else if (hit) mbox[n] <= be_merge(mbox[n], wdata, be);
    end
  end
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mask_t set_mask,
  input  mask_t clr_mask,
  input  logic  ena_we,
  input  mask_t ena_wdata,
  output mask_t sts,
  output mask_t ena,
  output logic  irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      ena <= '0;
      irq <= 1'b0;
    end else begin
      sts <= rw1c_next(sts, set_mask, clr_mask);
      if (ena_we) ena <= ena_wdata;
      irq <= |(sts & ena);
    end
  end
endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
#(
  parameter addr_t STS_OFF   = 14'h0040,
  parameter addr_t ENA_OFF   = 14'h0050,
  parameter addr_t OWN_BASE  = 14'h0800,
  parameter addr_t PEER_BASE = 14'h0900,
  localparam int SLOT_LSB = $clog2(MBX_BW),
  localparam int WIN_LSB  = SLOT_LSB + $clog2(MBX_NUM),
  localparam int DB_LANE  = DB_LSB / 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  addr_t                          addr,
  input  word_t                          wdata,
  input  logic [MBX_BW-1:0]              be,
  output word_t                          rdata,
  input  logic [MBX_NUM-1:0][MBX_DW-1:0] peer_mbox,
  input  mask_t                          peer_ring,
  output logic [MBX_NUM-1:0][MBX_DW-1:0] own_mbox,
  output mask_t                          own_ring,
  output mask_t                          sts,
  output mask_t                          ena,
  output logic                           irq
);
  logic sts_hit, ena_hit, own_hit, peer_hit;
  logic [WIN_LSB-SLOT_LSB-1:0] idx;
  mask_t clr_mask;
  logic  ena_we;

  assign sts_hit  = win_hit(addr, STS_OFF, SLOT_LSB);
  assign ena_hit  = win_hit(addr, ENA_OFF, SLOT_LSB);
  assign own_hit  = win_hit(addr, OWN_BASE, WIN_LSB);
  assign peer_hit = win_hit(addr, PEER_BASE, WIN_LSB);
  assign idx      = addr[WIN_LSB-1:SLOT_LSB];

  assign clr_mask = (we && sts_hit && be[DB_LANE]) ? wdata[DB_LSB +: MBX_NUM] : '0;
  assign ena_we   = we && ena_hit && be[DB_LANE];

  mbx_regfile #(.NMB(MBX_NUM)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we && own_hit),
    .idx   (idx),
    .wdata (wdata),
    .be    (be),
    .mbox  (own_mbox),
    .ring  (own_ring)
  );

  mbx_irq_unit u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_mask  (peer_ring),
    .clr_mask  (clr_mask),
    .ena_we    (ena_we),
    .ena_wdata (wdata[DB_LSB +: MBX_NUM]),
    .sts       (sts),
    .ena       (ena),
    .irq       (irq)
  );

  always_comb begin
    rdata = '0;
    if (sts_hit)       rdata[DB_LSB +: MBX_NUM] = sts;
    else if (ena_hit)  rdata[DB_LSB +: MBX_NUM] = ena;
    else if (own_hit)  rdata = own_mbox[idx];
    else if (peer_hit) rdata = peer_mbox[idx];
  end
endmodule

// File: rtl/mbox_doorbell_bridge.sv
module mbox_doorbell_bridge
  import mbx_pkg::*;
#(
  parameter addr_t A_STS  = 14'h0040,
  parameter addr_t A_ENA  = 14'h0050,
  parameter addr_t A_OWN  = 14'h0800,
  parameter addr_t A_PEER = 14'h0900,
  parameter addr_t B_STS  = 14'h3060,
  parameter addr_t B_ENA  = 14'h3070,
  parameter addr_t B_OWN  = 14'h3A00,
  parameter addr_t B_PEER = 14'h3B00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic [MBX_AW-1:0] a_addr,
  input  logic [MBX_DW-1:0] a_wdata,
  input  logic [MBX_BW-1:0] a_be,
  output logic [MBX_DW-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_we,
  input  logic [MBX_AW-1:0] b_addr,
  input  logic [MBX_DW-1:0] b_wdata,
  input  logic [MBX_BW-1:0] b_be,
  output logic [MBX_DW-1:0] b_rdata,
  output logic              b_irq
);
  // named internal events for the checker
  logic [MBX_NUM-1:0][MBX_DW-1:0] a_mbox, b_mbox;
  mask_t a_ring, b_ring;
  mask_t a_sts, b_sts, a_ena, b_ena;

  mbx_side #(.STS_OFF(A_STS), .ENA_OFF(A_ENA), .OWN_BASE(A_OWN), .PEER_BASE(A_PEER)) u_side_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (a_we),
    .addr      (a_addr),
    .wdata     (a_wdata),
    .be        (a_be),
    .rdata     (a_rdata),
    .peer_mbox (b_mbox),
    .peer_ring (b_ring),
    .own_mbox  (a_mbox),
    .own_ring  (a_ring),
    .sts       (a_sts),
    .ena       (a_ena),
    .irq       (a_irq)
  );

  mbx_side #(.STS_OFF(B_STS), .ENA_OFF(B_ENA), .OWN_BASE(B_OWN), .PEER_BASE(B_PEER)) u_side_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (b_we),
    .addr      (b_addr),
    .wdata     (b_wdata),
    .be        (b_be),
    .rdata     (b_rdata),
    .peer_mbox (a_mbox),
    .peer_ring (a_ring),
    .own_mbox  (b_mbox),
    .own_ring  (b_ring),
    .sts       (b_sts),
    .ena       (b_ena),
    .irq       (b_irq)
  );
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
  import mbx_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input mask_t a_ring,
  input mask_t b_ring,
  input mask_t a_sts,
  input mask_t b_sts,
  input mask_t a_ena,
  input mask_t b_ena,
  input logic  a_irq,
  input logic  b_irq
);
  // R3 R5
  a_ring_sets_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ring != '0) |=> ((b_sts & $past(a_ring)) == $past(a_ring)));

  // R3 R5
  b_ring_sets_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ring != '0) |=> ((a_sts & $past(b_ring)) == $past(b_ring)));

  // R3
  a_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ring == '0) |=> ((a_sts & ~$past(a_sts)) == '0));

  // R3
  b_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ring == '0) |=> ((b_sts & ~$past(b_sts)) == '0));

  // R7
  a_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_irq == |($past(a_sts) & $past(a_ena))));

  // R7
  b_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (b_irq == |($past(b_sts) & $past(b_ena))));
endmodule

bind mbox_doorbell_bridge mbx_doorbell_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .a_ring(a_ring),
  .b_ring(b_ring),
  .a_sts (a_sts),
  .b_sts (b_sts),
  .a_ena (a_ena),
  .b_ena (b_ena),
  .a_irq (a_irq),
  .b_irq (b_irq)
);

// File: tb/sim_mbox_doorbell_bridge.sv
module sim_mbox_doorbell_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_we = 1'b0, b_we = 1'b0;
  logic [13:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [3:0]  a_be = '0, b_be = '0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  always #5 clk = ~clk;

  mbox_doorbell_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_be(a_be), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_be(b_be), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  // reference state
  logic [31:0] ma [8];
  logic [31:0] mb [8];
  logic [7:0]  sa, sb, ea, eb;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] c, logic [31:0] d, logic [3:0] be);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_a(logic [13:0] ad);
    if (ad[13:2] == 12'h010) return {8'h0, sa, 16'h0};
    if (ad[13:2] == 12'h014) return {8'h0, ea, 16'h0};
    if (ad[13:5] == 9'h040)  return ma[ad[4:2]];
    if (ad[13:5] == 9'h048)  return mb[ad[4:2]];
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_b(logic [13:0] ad);
    if (ad[13:2] == 12'hC18) return {8'h0, sb, 16'h0};
    if (ad[13:2] == 12'hC1C) return {8'h0, eb, 16'h0};
    if (ad[13:5] == 9'h1D0)  return mb[ad[4:2]];
    if (ad[13:5] == 9'h1D8)  return ma[ad[4:2]];
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [13:0] ad, logic side_b);
    logic [11:0] w; logic [8:0] win;
    w = ad[13:2]; win = ad[13:5];
    if (w == (side_b ? 12'hC18 : 12'h010)) return "R3_R4";
    if (w == (side_b ? 12'hC1C : 12'h014)) return "R6";
    if (win == (side_b ? 9'h1D0 : 9'h040)) return "R1";
    if (win == (side_b ? 9'h1D8 : 9'h048)) return "R2";
    return "R8";
  endfunction

  task automatic rd_a(input logic [13:0] ad);
    a_addr = ad; #1;
    chk(a_rdata, exp_a(ad), tag_of(ad, 1'b0));
  endtask

  task automatic rd_b(input logic [13:0] ad);
    b_addr = ad; #1;
    chk(b_rdata, exp_b(ad), tag_of(ad, 1'b1));
  endtask

  // one cycle with both buses driven; reference updated afterwards
  task automatic step(input logic aw, input logic [13:0] aa, input logic [31:0] ad, input logic [3:0] abe,
                      input logic bw, input logic [13:0] ba, input logic [31:0] bd, input logic [3:0] bbe);
    logic [7:0] set_a, set_b, clr_a, clr_b;
    logic pa, pb;
    pa = |(sa & ea); pb = |(sb & eb);
    @(negedge clk);
    a_we = aw; a_addr = aa; a_wdata = ad; a_be = abe;
    b_we = bw; b_addr = ba; b_wdata = bd; b_be = bbe;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    // R7: output still reflects the state before this edge's update
    chk({31'h0, a_irq}, {31'h0, pa}, "R7");
    chk({31'h0, b_irq}, {31'h0, pb}, "R7");
    set_a = '0; set_b = '0; clr_a = '0; clr_b = '0;
    if (aw) begin
      if (aa[13:2] == 12'h010 && abe[2]) clr_a = ad[23:16];
      if (aa[13:2] == 12'h014 && abe[2]) ea = ad[23:16];
      if (aa[13:5] == 9'h040) begin
        ma[aa[4:2]] = merge(ma[aa[4:2]], ad, abe);
        if (|abe) set_b[aa[4:2]] = 1'b1;
      end
    end
    if (bw) begin
      if (ba[13:2] == 12'hC18 && bbe[2]) clr_b = bd[23:16];
      if (ba[13:2] == 12'hC1C && bbe[2]) eb = bd[23:16];
      if (ba[13:5] == 9'h1D0) begin
        mb[ba[4:2]] = merge(mb[ba[4:2]], bd, bbe);
        if (|bbe) set_a[ba[4:2]] = 1'b1;
      end
    end
    sa = (sa & ~clr_a) | set_a;
    sb = (sb & ~clr_b) | set_b;
  endtask

  task automatic idle_chk;
    @(negedge clk);
    chk({31'h0, a_irq}, {31'h0, |(sa & ea)}, "R7");
    chk({31'h0, b_irq}, {31'h0, |(sb & eb)}, "R7");
  endtask

  function automatic logic [13:0] pick_a();
    case ($urandom % 6)
      0: return 14'h0040;
      1: return 14'h0050;
      2: return 14'h0800 + 14'(($urandom % 8) * 4);
      3: return 14'h0900 + 14'(($urandom % 8) * 4);
      4: return 14'h0800 + 14'(($urandom % 8) * 4);
      default: return 14'($urandom);
    endcase
  endfunction

  function automatic logic [13:0] pick_b();
    case ($urandom % 6)
      0: return 14'h3060;
      1: return 14'h3070;
      2: return 14'h3A00 + 14'(($urandom % 8) * 4);
      3: return 14'h3B00 + 14'(($urandom % 8) * 4);
      4: return 14'h3A00 + 14'(($urandom % 8) * 4);
      default: return 14'($urandom);
    endcase
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin ma[i] = '0; mb[i] = '0; end
    sa = '0; sb = '0; ea = '0; eb = '0;
    // dirty the state, then reset
    rst_n = 1'b1;
    @(negedge clk);
    a_we = 1'b1; a_addr = 14'h0800; a_wdata = 32'hDEADBEEF; a_be = 4'hF;
    b_we = 1'b1; b_addr = 14'h3070; b_wdata = 32'h00FF0000; b_be = 4'hF;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: everything cleared by reset
    @(negedge clk);
    chk({31'h0, a_irq}, 32'h0, "R9");
    chk({31'h0, b_irq}, 32'h0, "R9");
    a_addr = 14'h0800; #1; chk(a_rdata, 32'h0, "R9");
    b_addr = 14'h3070; #1; chk(b_rdata, 32'h0, "R9");
    b_addr = 14'h3060; #1; chk(b_rdata, 32'h0, "R9");

    // R1 full write and partial-byte write on side A slot 3
    step(1, 14'h080C, 32'h11223344, 4'hF, 0, 14'h0, 32'h0, 4'h0);
    rd_a(14'h080C);
    step(1, 14'h080C, 32'hAABBCCDD, 4'b0101, 0, 14'h0, 32'h0, 4'h0);
    a_addr = 14'h080C; #1; chk(a_rdata, 32'h11BB33DD, "R1");
    // R2 side B sees it read-only, R3 doorbell bit 19 on side B
    b_addr = 14'h3B0C; #1; chk(b_rdata, 32'h11BB33DD, "R2");
    b_addr = 14'h3060; #1; chk(b_rdata, 32'h0008_0000, "R3");
    // R2 writes to peer windows ignored
    step(1, 14'h0904, 32'hFFFFFFFF, 4'hF, 1, 14'h3B0C, 32'h0, 4'hF);
    b_addr = 14'h3A04; #1; chk(b_rdata, 32'h0, "R2");
    a_addr = 14'h080C; #1; chk(a_rdata, 32'h11BB33DD, "R2");
    a_addr = 14'h0040; #1; chk(a_rdata, 32'h0, "R2");
    // R3 zero byte enables ring nothing
    step(0, 14'h0, 32'h0, 4'h0, 1, 14'h3A10, 32'h12345678, 4'h0);
    a_addr = 14'h0040; #1; chk(a_rdata, 32'h0, "R3");
    // R6 enable only bits 23:16, lane 2 needed
    step(0, 14'h0, 32'h0, 4'h0, 1, 14'h3070, 32'hFFFFFFFF, 4'b1011);
    b_addr = 14'h3070; #1; chk(b_rdata, 32'h0, "R6");
    step(0, 14'h0, 32'h0, 4'h0, 1, 14'h3070, 32'hFFFFFFFF, 4'hF);
    b_addr = 14'h3070; #1; chk(b_rdata, 32'h00FF_0000, "R6");
    // R7 irq follows one cycle later
    idle_chk();
    chk({31'h0, b_irq}, 32'h1, "R7");
    // R4 writing zero / lane 2 off keeps bit
    step(0, 14'h0, 32'h0, 4'h0, 1, 14'h3060, 32'h0, 4'hF);
    step(0, 14'h0, 32'h0, 4'h0, 1, 14'h3060, 32'hFFFFFFFF, 4'b1011);
    b_addr = 14'h3060; #1; chk(b_rdata, 32'h0008_0000, "R4");
    // R5 set and clear of bit 19 in the same cycle, plus a new set on bit 21
    step(1, 14'h080C, 32'h0, 4'h1, 1, 14'h3060, 32'h00FF0000, 4'h4);
    b_addr = 14'h3060; #1; chk(b_rdata, 32'h0008_0000, "R5");
    step(1, 14'h0814, 32'h5, 4'h1, 1, 14'h3060, 32'h00080000, 4'h4);
    b_addr = 14'h3060; #1; chk(b_rdata, 32'h0020_0000, "R5");
    // R4 clear works
    step(0, 14'h0, 32'h0, 4'h0, 1, 14'h3060, 32'h00200000, 4'h4);
    b_addr = 14'h3060; #1; chk(b_rdata, 32'h0, "R4");
    idle_chk();
    // R8 unmapped reads
    rd_a(14'h0044); rd_a(14'h0A00); rd_a(14'h3060);
    rd_b(14'h0040); rd_b(14'h3064); rd_b(14'h3C00);

    // random mix
    for (int it = 0; it < 1500; it++) begin
      logic [3:0] abe, bbe;
      abe = 4'($urandom); bbe = 4'($urandom);
      if ($urandom % 3 == 0) abe = 4'hF;
      if ($urandom % 3 == 0) bbe = 4'hF;
      step(1'($urandom), pick_a(), $urandom, abe, 1'($urandom), pick_b(), $urandom, bbe);
      if (it % 4 == 0) idle_chk();
      rd_a(pick_a()); rd_a(pick_a());
      rd_b(pick_b()); rd_b(pick_b());
    end
    // final sweep of all registers
    for (int i = 0; i < 8; i++) begin
      rd_a(14'(14'h0800 + i * 4)); rd_a(14'(14'h0900 + i * 4));
      rd_b(14'(14'h3A00 + i * 4)); rd_b(14'(14'h3B00 + i * 4));
    end
    rd_a(14'h0040); rd_a(14'h0050); rd_b(14'h3060); rd_b(14'h3070);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule